// File: doc/BRIEF.md
# Line-Locked PI Loop with Numerically Controlled Oscillator

This block is the loop filter and oscillator of a digital horizontal-sync PLL. Once per video line, an upstream phase detector presents a signed phase error together with a valid strobe. A proportional-integral filter turns that error into a frequency increment. The increment is added to a phase accumulator on every system clock, and each carry out of the accumulator is one output-clock tick enable. A pixel-position counter advances on each tick and wraps after 864 positions. When the loop is locked, one line therefore holds exactly 864 ticks.

Three register inputs shape the loop. A 5-bit nominal setting selects the centre frequency. A gain-mode bit swaps in a second coefficient set, either one suited to a clean broadcast source or one suited to a jittery tape source. A generator bit opens the loop, so that the oscillator runs at the nominal frequency alone.

Top module: `hsync_loop_nco`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets `pixel_pos` to 0, `tick_en` to 0 and the integrator to 0. It also loads `freq_inc` with the nominal base value of R8.
- R2: `pixel_pos` advances by one in the same cycle that `tick_en` is high. After LINE_TICKS-1 (863 by default) it wraps to 0. Without a tick it holds.
- R3: The integrator is clamped to the range -INT_LIMIT to +INT_LIMIT. The sum that forms the increment is clamped to the range 0 to 2^ACC_W-1, so neither value can wrap.
- R4: While `gen_mode` is 1, the integrator is held at 0, the phase error is ignored, and `freq_inc` takes the base value one edge later.
- R5: With `gen_mode` at 0 and `err_valid` low, `freq_inc` and the integrator keep their values.
- R6: At an edge where `err_valid` is 1 and `gen_mode` is 0, the integrator becomes I + (e << KI). `freq_inc` becomes base + (e << KP) + the new integrator value, and is visible after that edge.
- R7: When `vcr_mode` is 0, the shifts KP_SH_TV and KI_SH_TV apply. When it is 1, the shifts KP_SH_VCR and KI_SH_VCR apply.
- R8: The base increment equals BASE_INC + `nom_sel` * NOM_STEP, for `nom_sel` values 0 to 31.
- R9: The accumulator adds `freq_inc` on every clock. `tick_en` is the registered carry out, so N clocks give N*`freq_inc`/2^ACC_W ticks, give or take one.
- R10: When the phase error is fed back once per fixed-length line, the tick count per line settles at LINE_TICKS in both gain modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nom_sel | input | NOM_W | Nominal frequency setting, 0 to 31 |
| vcr_mode | input | 1 | 1 selects the tape-source gain set |
| gen_mode | input | 1 | 1 opens the loop (free-running generator) |
| err_valid | input | 1 | One-cycle strobe, once per line |
| phase_err | input | ERR_W | Signed phase error, in ticks; positive means the oscillator is behind |
| tick_en | output | 1 | Output-clock tick enable |
| pixel_pos | output | POS_W | Position within the line, 0 to LINE_TICKS-1 |
| freq_inc | output | ACC_W | Current oscillator increment |

## Verification
The bench builds the block with a 14-bit accumulator, BASE_INC 11264, NOM_STEP 64 and INT_LIMIT 1024. With these values a setting of 16 gives exactly three ticks every four clocks, and a 1152-clock line then holds 864 ticks. Both increment clamps, and the integrator limit, can be reached with a single error of 2000. A 256-unit offset from the nominal setting makes the integrator do real work, and the loop settles within about fifty lines, so lock in both gain modes fits in the run. Exact tick counts over 1024-clock windows can also be predicted in generator mode.

// File: rtl/hloop_pkg.sv
// Package: shared types for the line-locked loop.
// Assumes shift amounts fit in five bits.
package hloop_pkg;

    // Gain set selected by the mode bit
    typedef enum logic {
        GAIN_BCAST = 1'b0,
        GAIN_TAPE  = 1'b1
    } gain_sel_e;

    // Left-shift amounts for the proportional and integral paths
    typedef struct packed {
        logic [4:0] kp_sh;
        logic [4:0] ki_sh;
    } pi_shift_t;

endpackage

// File: rtl/hloop_base_calc.sv
// Base increment: BASE_INC plus the nominal setting times NOM_STEP.
// Assumes the result fits in ACC_W bits for every setting.
module hloop_base_calc #(
    parameter int ACC_W    = 24,
    parameter int NOM_W    = 5,
    parameter int BASE_INC = 8126464,
    parameter int NOM_STEP = 16384
) (
    input  logic [NOM_W-1:0] nom_sel,
    output logic [ACC_W-1:0] base_inc
);
    localparam logic [ACC_W-1:0] BASE_C = ACC_W'(BASE_INC);
    localparam logic [ACC_W-1:0] STEP_C = ACC_W'(NOM_STEP);

    // Purpose: linear map from the setting to the centre increment
    always_comb begin
        base_inc = BASE_C + ACC_W'(nom_sel) * STEP_C;
    end
endmodule

// File: rtl/hloop_pi_filter.sv
// PI filter: updates the integrator and the increment on each valid
// error strobe, and holds both in between. Generator mode clears the
// integrator and loads the base value every cycle. Assumes that
// ERR_W plus the largest shift stays below ACC_W+3.
module hloop_pi_filter
    import hloop_pkg::*;
#(
    parameter int ACC_W     = 24,
    parameter int ERR_W     = 12,
    parameter int INT_LIMIT = 1048576,
    parameter int KP_SH_TV  = 3,
    parameter int KI_SH_TV  = 0,
    parameter int KP_SH_VCR = 3,
    parameter int KI_SH_VCR = 1,
    localparam int SUM_W    = ACC_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ACC_W-1:0]        base_inc,
    input  logic                    vcr_mode,
    input  logic                    gen_mode,
    input  logic                    err_valid,
    input  logic signed [ERR_W-1:0] phase_err,
    output logic [ACC_W-1:0]        freq_inc,
    output logic signed [SUM_W-1:0] integ
);
    localparam logic signed [SUM_W-1:0] LIM_P   = SUM_W'(INT_LIMIT);
    localparam logic signed [SUM_W-1:0] LIM_N   = -LIM_P;
    localparam logic signed [SUM_W-1:0] INC_MAX = SUM_W'((64'd1 << ACC_W) - 64'd1);

    pi_shift_t                 gains [2];
    gain_sel_e                 sel;
    pi_shift_t                 cur;
    logic signed [SUM_W-1:0]   e_ext;
    logic signed [SUM_W-1:0]   integ_raw;
    logic signed [SUM_W-1:0]   integ_nx;
    logic signed [SUM_W-1:0]   prop;
    logic signed [SUM_W-1:0]   inc_raw;
    logic [ACC_W-1:0]          inc_sat;
    logic signed [SUM_W-1:0]   integ_q;
    logic [ACC_W-1:0]          inc_q;

    // Purpose: fill the two-entry gain table from the parameters
    generate
        for (genvar g = 0; g < 2; g++) begin : g_gain
            if (g == 0) begin : g_bcast
                assign gains[g] = '{kp_sh: 5'(KP_SH_TV),  ki_sh: 5'(KI_SH_TV)};
            end else begin : g_tape
                assign gains[g] = '{kp_sh: 5'(KP_SH_VCR), ki_sh: 5'(KI_SH_VCR)};
            end
        end
    endgenerate

    // Purpose: choose the gain set that the mode bit asks for
    always_comb begin
        sel = gain_sel_e'(vcr_mode);
        cur = gains[sel];
    end

    // Purpose: saturating integrator step and clamped increment sum
    always_comb begin
        e_ext     = SUM_W'(phase_err);
        integ_raw = integ_q + (e_ext <<< cur.ki_sh);
        if (integ_raw > LIM_P) begin
            integ_nx = LIM_P;
        end else if (integ_raw < LIM_N) begin
            integ_nx = LIM_N;
        end else begin
            integ_nx = integ_raw;
        end
        prop    = e_ext <<< cur.kp_sh;
        inc_raw = $signed({3'b000, base_inc}) + prop + integ_nx;
        if (inc_raw < 0) begin
            inc_sat = '0;
        end else if (inc_raw > INC_MAX) begin
            inc_sat = '1;
        end else begin
            inc_sat = inc_raw[ACC_W-1:0];
        end
    end

    // Purpose: register the filter state once per strobe, or hold it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ_q <= '0;
            inc_q   <= base_inc;
        end else if (gen_mode) begin
            integ_q <= '0;
            inc_q   <= base_inc;
        end else if (err_valid) begin
            integ_q <= integ_nx;
            inc_q   <= inc_sat;
        end
    end

    assign freq_inc = inc_q;
    assign integ    = integ_q;
endmodule

// File: rtl/hloop_nco.sv
// Phase accumulator: adds the increment each clock and emits the
// registered carry as a tick enable. Assumes increment below 2^ACC_W.
module hloop_nco #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] freq_inc,
    output logic             tick_en
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    // Purpose: one extra bit catches the carry out
    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, freq_inc};
    end

    // Purpose: advance the phase and register the carry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            tick_en <= 1'b0;
        end else begin
            acc_q   <= sum[ACC_W-1:0];
            tick_en <= sum[ACC_W];
        end
    end
endmodule

// File: rtl/hloop_line_pos.sv
// Position counter: steps on each carry and wraps after LINE_TICKS
// positions. It is fed the same carry that the tick register takes,
// so position and tick change at the same edge.
module hloop_line_pos #(
    parameter int LINE_TICKS = 864,
    localparam int POS_W     = $clog2(LINE_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] LAST = POS_W'(LINE_TICKS - 1);

    // Purpose: count ticks modulo the line length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (step) begin
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end
endmodule

// File: rtl/hsync_loop_nco.sv
// Top level: base calculation, PI filter, oscillator and position
// counter. Assumes one error strobe per line, from a phase detector
// outside this block.
module hsync_loop_nco #(
    parameter int ACC_W      = 24,
    parameter int ERR_W      = 12,
    parameter int NOM_W      = 5,
    parameter int LINE_TICKS = 864,
    parameter int BASE_INC   = 8126464,
    parameter int NOM_STEP   = 16384,
    parameter int INT_LIMIT  = 1048576,
    parameter int KP_SH_TV   = 3,
    parameter int KI_SH_TV   = 0,
    parameter int KP_SH_VCR  = 3,
    parameter int KI_SH_VCR  = 1,
    localparam int POS_W     = $clog2(LINE_TICKS),
    localparam int SUM_W     = ACC_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NOM_W-1:0]        nom_sel,
    input  logic                    vcr_mode,
    input  logic                    gen_mode,
    input  logic                    err_valid,
    input  logic signed [ERR_W-1:0] phase_err,
    output logic                    tick_en,
    output logic [POS_W-1:0]        pixel_pos,
    output logic [ACC_W-1:0]        freq_inc
);
    logic [ACC_W-1:0]        base_inc;
    logic signed [SUM_W-1:0] integ;
    logic                    carry_step;

    hloop_base_calc #(
        .ACC_W(ACC_W), .NOM_W(NOM_W), .BASE_INC(BASE_INC), .NOM_STEP(NOM_STEP)
    ) u_base (
        .nom_sel(nom_sel), .base_inc(base_inc)
    );

    hloop_pi_filter #(
        .ACC_W(ACC_W), .ERR_W(ERR_W), .INT_LIMIT(INT_LIMIT),
        .KP_SH_TV(KP_SH_TV), .KI_SH_TV(KI_SH_TV),
        .KP_SH_VCR(KP_SH_VCR), .KI_SH_VCR(KI_SH_VCR)
    ) u_filt (
        .clk(clk), .rst_n(rst_n), .base_inc(base_inc), .vcr_mode(vcr_mode),
        .gen_mode(gen_mode), .err_valid(err_valid), .phase_err(phase_err),
        .freq_inc(freq_inc), .integ(integ)
    );

    hloop_nco #(.ACC_W(ACC_W)) u_nco (
        .clk(clk), .rst_n(rst_n), .freq_inc(freq_inc), .tick_en(tick_en)
    );

    // Purpose: the counter steps on the carry that becomes the next tick
    assign carry_step = ({1'b0, u_nco.acc_q} + {1'b0, freq_inc}) >> ACC_W != '0;

    hloop_line_pos #(.LINE_TICKS(LINE_TICKS)) u_pos (
        .clk(clk), .rst_n(rst_n), .step(carry_step), .pos(pixel_pos)
    );
endmodule

// File: rtl/hsync_loop_nco_sva.sv
// Checker: temporal properties of the loop, bound into the top.
module hsync_loop_nco_sva #(
    parameter int ACC_W      = 24,
    parameter int LINE_TICKS = 864,
    parameter int INT_LIMIT  = 1048576,
    localparam int POS_W     = $clog2(LINE_TICKS),
    localparam int SUM_W     = ACC_W + 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick_en,
    input logic [POS_W-1:0]        pixel_pos,
    input logic [ACC_W-1:0]        freq_inc,
    input logic [ACC_W-1:0]        base_inc,
    input logic                    err_valid,
    input logic                    gen_mode,
    input logic signed [SUM_W-1:0] integ
);
    localparam logic [POS_W-1:0]        LAST  = POS_W'(LINE_TICKS - 1);
    localparam logic signed [SUM_W-1:0] LIM_P = SUM_W'(INT_LIMIT);

    p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pixel_pos <= LAST);

    p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && tick_en |->
            pixel_pos == (($past(pixel_pos) == LAST) ? '0 : $past(pixel_pos) + 1'b1));

    p_pos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !tick_en |-> $stable(pixel_pos));

    p_integ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (integ <= LIM_P) && (integ >= -LIM_P));

    p_gen_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gen_mode) |-> (freq_inc == $past(base_inc)) && (integ == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(err_valid) && !$past(gen_mode) |->
            $stable(freq_inc) && $stable(integ));
endmodule

bind hsync_loop_nco hsync_loop_nco_sva #(
    .ACC_W(ACC_W), .LINE_TICKS(LINE_TICKS), .INT_LIMIT(INT_LIMIT)
) u_sva (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pixel_pos(pixel_pos),
    .freq_inc(freq_inc), .base_inc(base_inc), .err_valid(err_valid),
    .gen_mode(gen_mode), .integ(integ)
);

// File: tb/hsync_loop_nco_bench.sv
// Directed bench: one task per scenario, each checks its own results.
module hsync_loop_nco_bench;
    localparam int ACC_W = 14;
    localparam int ERR_W = 12;
    localparam int LT    = 864;
    localparam int LINE  = 1152;
    localparam int BASE  = 11264;
    localparam int STEP  = 64;
    localparam int POS_W = $clog2(LT);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [4:0]              nom_sel = 5'd12;
    logic                    vcr_mode = 1'b0;
    logic                    gen_mode = 1'b0;
    logic                    err_valid = 1'b0;
    logic signed [ERR_W-1:0] phase_err = '0;
    logic                    tick_en;
    logic [POS_W-1:0]        pixel_pos;
    logic [ACC_W-1:0]        freq_inc;

    int checks = 0;
    int fails  = 0;
    int pos_bad = 0;
    int wraps   = 0;
    bit finished = 1'b0;

    hsync_loop_nco #(
        .ACC_W(ACC_W), .ERR_W(ERR_W), .LINE_TICKS(LT), .BASE_INC(BASE),
        .NOM_STEP(STEP), .INT_LIMIT(1024), .KP_SH_TV(3), .KI_SH_TV(0),
        .KP_SH_VCR(3), .KI_SH_VCR(1)
    ) u_hsync_loop_nco (
        .clk(clk), .rst_n(rst_n), .nom_sel(nom_sel), .vcr_mode(vcr_mode),
        .gen_mode(gen_mode), .err_valid(err_valid), .phase_err(phase_err),
        .tick_en(tick_en), .pixel_pos(pixel_pos), .freq_inc(freq_inc)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2 monitor: the position follows the ticks, sampled at negedges
    always @(negedge clk) begin : pos_mon
        static int prev = 0;
        if (!rst_n) begin
            prev = 0;
        end else begin
            if (tick_en) begin
                if (int'(pixel_pos) != ((prev == LT - 1) ? 0 : prev + 1)) pos_bad++;
                if (prev == LT - 1) wraps++;
            end else if (int'(pixel_pos) != prev) begin
                pos_bad++;
            end
            prev = int'(pixel_pos);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic strobe(input int e, input bit tape);
        vcr_mode  = tape;
        phase_err = ERR_W'(e);
        err_valid = 1'b1;
        @(negedge clk);
        err_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        nom_sel = 5'd12;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(pixel_pos == 0, "R1 pos", pixel_pos, 0);
        chk(tick_en == 1'b0, "R1 tick", tick_en, 0);
        chk(int'(freq_inc) == BASE + 12 * STEP, "R1/R8 base", freq_inc, BASE + 12 * STEP);
        rst_n = 1'b1;
    endtask

    task automatic t_filter();
        strobe(5, 1'b0);
        chk(int'(freq_inc) == 12077, "R6 bcast step", freq_inc, 12077);
        strobe(5, 1'b1);
        chk(int'(freq_inc) == 12087, "R7 tape gains", freq_inc, 12087);
        repeat (10) @(negedge clk);
        chk(int'(freq_inc) == 12087, "R5 hold without strobe", freq_inc, 12087);
        strobe(2000, 1'b0);
        chk(int'(freq_inc) == 16383, "R3 increment clamp high", freq_inc, 16383);
        strobe(0, 1'b0);
        chk(int'(freq_inc) == 13056, "R3 integrator limit +", freq_inc, 13056);
        strobe(-2000, 1'b0);
        chk(int'(freq_inc) == 0, "R3 increment clamp low", freq_inc, 0);
        strobe(-2000, 1'b0);
        strobe(0, 1'b0);
        chk(int'(freq_inc) == 11008, "R3 integrator limit -", freq_inc, 11008);
    endtask

    task automatic t_generator();
        int cnt;
        gen_mode = 1'b1;
        @(negedge clk);
        chk(int'(freq_inc) == 12032, "R4 base in generator", freq_inc, 12032);
        strobe(100, 1'b0);
        chk(int'(freq_inc) == 12032, "R4 error ignored", freq_inc, 12032);
        gen_mode = 1'b0;
        strobe(0, 1'b0);
        chk(int'(freq_inc) == 12032, "R4 integrator cleared", freq_inc, 12032);
        gen_mode = 1'b1;
        nom_sel  = 5'd16;
        repeat (3) @(negedge clk);
        chk(int'(freq_inc) == BASE + 16 * STEP, "R8 setting 16", freq_inc, BASE + 16 * STEP);
        cnt = 0;
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            if (tick_en) cnt++;
        end
        chk(cnt == 768, "R9 ticks setting 16", cnt, 768);
        nom_sel = 5'd0;
        repeat (3) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            if (tick_en) cnt++;
        end
        chk(cnt == 704, "R9 ticks setting 0", cnt, 704);
        gen_mode = 1'b0;
    endtask

    task automatic t_lock(input bit tape, input string tag);
        int cnt;
        int maxe;
        int e;
        nom_sel  = 5'd12;
        vcr_mode = tape;
        do_reset();
        cnt  = 0;
        maxe = 0;
        for (int ln = 0; ln < 58; ln++) begin
            for (int c = 0; c < LINE; c++) begin
                @(negedge clk);
                if (ln >= 50 && tick_en) cnt++;
                if (c == 0) begin
                    e = (int'(pixel_pos) < LT / 2) ? -int'(pixel_pos) : LT - int'(pixel_pos);
                    if (ln >= 50 && (e > maxe || -e > maxe)) maxe = (e < 0) ? -e : e;
                    phase_err = ERR_W'(e);
                    err_valid = 1'b1;
                end else begin
                    err_valid = 1'b0;
                end
            end
        end
        chk(cnt >= 8 * LT - 2 && cnt <= 8 * LT + 2, {"R10 ticks per 8 lines ", tag}, cnt, 8 * LT);
        chk(maxe <= 2, {"R10 residual error ", tag}, maxe, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        t_reset_state();
        t_filter();
        t_generator();
        t_lock(1'b0, "bcast");
        t_lock(1'b1, "tape");
        chk(pos_bad == 0, "R2 position follows ticks", pos_bad, 0);
        chk(wraps > 0, "R2 wrap seen", wraps, 1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule